// File: doc/BRIEF.md
# One-Time-Programmable Area Lock Controller

This block holds a one-time-programmable region of 1024 words of 16 bits (2 kB), together with a 32-bit lock word. Each lock bit covers one group of 32 consecutive words. A word counts as blank while it reads all ones. Only a blank word may be programmed, and programming is done one whole word at a time. Nothing in the region can be erased. After power-up the region is modelled as blank and the lock word as clear.

Programming can be refused for three reasons, each independent of the others. The target word already holds data, its group has been locked, or the global write-protect input is high. That input also refuses requests to set lock bits. A lock request can only add bits to the lock word and never removes any. A granted request raises an accept strobe for one cycle. A refused request leaves all storage as it was and raises an error flag for one cycle. Reads are always allowed, on a separate address port, with one cycle of latency.

Top module: `otp_area_ctrl`

## Requirements
- R1: While reset is held and right after it, the accept and error outputs are low, the read port returns 0xFFFF for every address, and no lock bit is set.
- R2: The read port returns the word at the address presented one cycle earlier. A program of that same word in that same cycle is not yet visible in this read.
- R3: A program request to a blank word (one that reads 0xFFFF) is granted when its group is unlocked and write protect is low. The word then holds the new data, and the accept output is high in the following cycle.
- R4: A program request to a word that does not read 0xFFFF is refused. The word keeps its value, and the error output is high for exactly the following cycle.
- R5: Lock bit g (bit g of the lock request mask) refuses programming of words 32*g to 32*g+31, that is, of every word whose address bits [9:5] equal g. Words in other groups stay programmable.
- R6: A granted lock request ORs the request mask into the lock word. Bits can be set but never cleared, and a mask of all zeros leaves the lock word unchanged.
- R7: While write protect is high, every program request and every lock request is refused. The error output goes high, the accept output stays low, and data and lock bits are unchanged.
- R8: A lock request and a program request in the same cycle are both judged against the lock word as it stood before that cycle. Accept is high if either is granted, and error is high if either is refused.
- R9: In a cycle with no request, the following cycle has accept and error both low.
- R10: Programming a blank word with 0xFFFF is granted and leaves the word blank, so that word can still be programmed later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prog_req_i | input | 1 | Request to program one word |
| prog_addr_i | input | 10 | Word address of the program request |
| prog_data_i | input | 16 | Data to program |
| lock_req_i | input | 1 | Request to set lock bits |
| lock_mask_i | input | 32 | Lock bits to set, bit g covers group g |
| wp_en_i | input | 1 | Global write protect, refuses all requests |
| rd_addr_i | input | 10 | Read word address |
| rd_data_o | output | 16 | Read data, one cycle after the address |
| ack_o | output | 1 | One-cycle strobe: a request was granted |
| err_o | output | 1 | One-cycle flag: a request was refused |

## Verification
Four behaviours are checked on every cycle. Write protect forces a refusal. A request aimed at a locked group raises the error flag. The lock word never loses a bit. No strobe appears without a request in the previous cycle. Other behaviours show only in the bench's scenarios, which compare each clock against a behavioural model. These are the one-time rule for non-blank words, the exact data that a program leaves behind, the read-before-write ordering on a shared address, and the same-cycle lock and program case. A final sweep over every address shows that refused requests never changed a stored word.

// File: rtl/otp_area_pkg.sv
package otp_area_pkg;

   // Verdict of the request judge for one kind of request in one cycle.
   typedef enum logic [1:0] {
      VERDICT_IDLE  = 2'b00,
      VERDICT_GRANT = 2'b01,
      VERDICT_DENY  = 2'b10
   } verdict_e;

   // Both verdicts of one cycle, passed from the judge to the top.
   typedef struct packed {
      verdict_e prog;
      verdict_e lock;
   } verdict_pair_t;

endpackage

// File: rtl/otp_lock_bank.sv
module otp_lock_bank #(
   parameter int NUM_GROUPS = 32
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  set_en_i,
   input  logic [NUM_GROUPS-1:0] set_mask_i,
   output logic [NUM_GROUPS-1:0] lock_q_o
);

   // One set-only flop per group; nothing but reset ever clears a bit.
   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_bit
      logic bit_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            bit_q <= 1'b0;
         end else if (set_en_i && set_mask_i[g]) begin
            bit_q <= 1'b1;
         end
      end

      assign lock_q_o[g] = bit_q;
   end

endmodule

// File: rtl/otp_word_array.sv
module otp_word_array #(
   parameter int WORD_W    = 16,
   parameter int NUM_WORDS = 1024,
   parameter int ADDR_W    = 10
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [WORD_W-1:0] wr_data_i,
   input  logic [ADDR_W-1:0] chk_addr_i,
   output logic              chk_blank_o,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [WORD_W-1:0] rd_data_o
);

   localparam logic [WORD_W-1:0] BLANK_WORD = '1;

   logic [WORD_W-1:0] cells_q [NUM_WORDS];
   logic [WORD_W-1:0] rd_q;

   // Storage: all words blank after reset, one word written per cycle.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int r = 0; r < NUM_WORDS; r++) begin
            cells_q[r] <= BLANK_WORD;
         end
      end else if (wr_en_i) begin
         cells_q[wr_addr_i] <= wr_data_i;
      end
   end

   // Registered read port; sees contents from before this edge's write.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rd_q <= BLANK_WORD;
      end else begin
         rd_q <= cells_q[rd_addr_i];
      end
   end

   assign chk_blank_o = (cells_q[chk_addr_i] == BLANK_WORD);
   assign rd_data_o   = rd_q;

endmodule

// File: rtl/otp_req_judge.sv
module otp_req_judge
   import otp_area_pkg::*;
#(
   parameter int ADDR_W      = 10,
   parameter int NUM_GROUPS  = 32,
   parameter int GROUP_SHIFT = 5
) (
   input  logic                  prog_req_i,
   input  logic [ADDR_W-1:0]     prog_addr_i,
   input  logic                  word_blank_i,
   input  logic                  lock_req_i,
   input  logic                  wp_en_i,
   input  logic [NUM_GROUPS-1:0] lock_q_i,
   output verdict_pair_t         verdict_o
);

   localparam int GRP_W = ADDR_W - GROUP_SHIFT;

   logic [GRP_W-1:0] grp_idx;
   logic             grp_locked;
   logic             prog_block;

   assign grp_idx    = prog_addr_i[ADDR_W-1:GROUP_SHIFT];
   assign grp_locked = lock_q_i[grp_idx];
   assign prog_block = wp_en_i || grp_locked || !word_blank_i;

   always_comb begin
      verdict_o.prog = VERDICT_IDLE;
      verdict_o.lock = VERDICT_IDLE;
      if (prog_req_i) begin
         verdict_o.prog = prog_block ? VERDICT_DENY : VERDICT_GRANT;
      end
      if (lock_req_i) begin
         verdict_o.lock = wp_en_i ? VERDICT_DENY : VERDICT_GRANT;
      end
   end

endmodule

// File: rtl/otp_area_ctrl.sv
module otp_area_ctrl
   import otp_area_pkg::*;
#(
   parameter  int WORD_W      = 16,
   parameter  int NUM_WORDS   = 1024,
   parameter  int GROUP_WORDS = 32,
   localparam int ADDR_W      = $clog2(NUM_WORDS),
   localparam int NUM_GROUPS  = NUM_WORDS / GROUP_WORDS,
   localparam int GROUP_SHIFT = $clog2(GROUP_WORDS)
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  prog_req_i,
   input  logic [ADDR_W-1:0]     prog_addr_i,
   input  logic [WORD_W-1:0]     prog_data_i,
   input  logic                  lock_req_i,
   input  logic [NUM_GROUPS-1:0] lock_mask_i,
   input  logic                  wp_en_i,
   input  logic [ADDR_W-1:0]     rd_addr_i,
   output logic [WORD_W-1:0]     rd_data_o,
   output logic                  ack_o,
   output logic                  err_o
);

   // Elaboration-time parameter checks.
   if ((NUM_WORDS & (NUM_WORDS - 1)) != 0) begin : g_bad_depth
      $error("NUM_WORDS must be a power of two");
   end
   if ((GROUP_WORDS & (GROUP_WORDS - 1)) != 0) begin : g_bad_group
      $error("GROUP_WORDS must be a power of two");
   end
   if (NUM_GROUPS < 2) begin : g_bad_count
      $error("at least two lock groups are required");
   end
   if (WORD_W < 1) begin : g_bad_width
      $error("WORD_W must be positive");
   end

   logic [NUM_GROUPS-1:0] lock_q;
   logic                  word_blank;
   verdict_pair_t         verdict;
   logic                  prog_grant;
   logic                  lock_grant;
   logic                  any_deny;
   logic                  ack_q;
   logic                  err_q;

   otp_req_judge #(
      .ADDR_W      (ADDR_W),
      .NUM_GROUPS  (NUM_GROUPS),
      .GROUP_SHIFT (GROUP_SHIFT)
   ) i_judge (
      .prog_req_i   (prog_req_i),
      .prog_addr_i  (prog_addr_i),
      .word_blank_i (word_blank),
      .lock_req_i   (lock_req_i),
      .wp_en_i      (wp_en_i),
      .lock_q_i     (lock_q),
      .verdict_o    (verdict)
   );

   assign prog_grant = (verdict.prog == VERDICT_GRANT);
   assign lock_grant = (verdict.lock == VERDICT_GRANT);
   assign any_deny   = (verdict.prog == VERDICT_DENY) || (verdict.lock == VERDICT_DENY);

   otp_word_array #(
      .WORD_W    (WORD_W),
      .NUM_WORDS (NUM_WORDS),
      .ADDR_W    (ADDR_W)
   ) i_array (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_en_i     (prog_grant),
      .wr_addr_i   (prog_addr_i),
      .wr_data_i   (prog_data_i),
      .chk_addr_i  (prog_addr_i),
      .chk_blank_o (word_blank),
      .rd_addr_i   (rd_addr_i),
      .rd_data_o   (rd_data_o)
   );

   otp_lock_bank #(
      .NUM_GROUPS (NUM_GROUPS)
   ) i_locks (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .set_en_i   (lock_grant),
      .set_mask_i (lock_mask_i),
      .lock_q_o   (lock_q)
   );

   // Status strobes, one cycle after the request.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ack_q <= 1'b0;
         err_q <= 1'b0;
      end else begin
         ack_q <= prog_grant || lock_grant;
         err_q <= any_deny;
      end
   end

   assign ack_o = ack_q;
   assign err_o = err_q;

endmodule

// File: rtl/otp_area_checker.sv
module otp_area_checker #(
   parameter int ADDR_W      = 10,
   parameter int NUM_GROUPS  = 32,
   parameter int GROUP_SHIFT = 5
) (
   input logic                  clk_i,
   input logic                  rst_ni,
   input logic                  prog_req_i,
   input logic [ADDR_W-1:0]     prog_addr_i,
   input logic                  lock_req_i,
   input logic                  wp_en_i,
   input logic [NUM_GROUPS-1:0] lock_q_i,
   input logic                  ack_o,
   input logic                  err_o
);

   // R7: write protect refuses every request
   p_wp_refuses_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wp_en_i && (prog_req_i || lock_req_i) |=> err_o && !ack_o);

   // R5: a program aimed at a locked group is refused
   p_locked_group_refused_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      prog_req_i && !lock_req_i && lock_q_i[prog_addr_i[ADDR_W-1:GROUP_SHIFT]]
      |=> err_o && !ack_o);

   // R6: lock bits are never cleared
   p_lock_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lock_q_i & $past(lock_q_i)) == $past(lock_q_i));

   // R9: no request, no strobe
   p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !prog_req_i && !lock_req_i |=> !ack_o && !err_o);

   // R3: an accept strobe always has a request behind it
   p_ack_has_cause_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ack_o |-> $past(prog_req_i || lock_req_i));

endmodule

bind otp_area_ctrl otp_area_checker #(
   .ADDR_W      (ADDR_W),
   .NUM_GROUPS  (NUM_GROUPS),
   .GROUP_SHIFT (GROUP_SHIFT)
) i_otp_area_checker (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .prog_req_i  (prog_req_i),
   .prog_addr_i (prog_addr_i),
   .lock_req_i  (lock_req_i),
   .wp_en_i     (wp_en_i),
   .lock_q_i    (lock_q),
   .ack_o       (ack_o),
   .err_o       (err_o)
);

// File: tb/test_otp_area_ctrl.sv
module test_otp_area_ctrl;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        prog_req;
   logic [9:0]  prog_addr;
   logic [15:0] prog_data;
   logic        lock_req;
   logic [31:0] lock_mask;
   logic        wp_en;
   logic [9:0]  rd_addr;
   logic [15:0] rd_data;
   logic        ack;
   logic        err;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   logic [15:0] mem_m [1024];
   logic [31:0] lock_m;

   always #(CLK_PERIOD / 2) clk = ~clk;

   otp_area_ctrl i_otp_area_ctrl (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .prog_req_i  (prog_req),
      .prog_addr_i (prog_addr),
      .prog_data_i (prog_data),
      .lock_req_i  (lock_req),
      .lock_mask_i (lock_mask),
      .wp_en_i     (wp_en),
      .rd_addr_i   (rd_addr),
      .rd_data_o   (rd_data),
      .ack_o       (ack),
      .err_o       (err)
   );

   task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
      end
   endtask

   // One clock: drive at negedge, update the model at the edge, compare at the next negedge.
   task automatic cyc(string tag, bit pr, int pa, logic [15:0] pd,
                      bit lr, logic [31:0] lm, bit wp, int ra);
      logic [15:0] exp_rd;
      logic [31:0] pre_lock;
      bit acc;
      bit rej;
      prog_req  = pr;
      prog_addr = pa[9:0];
      prog_data = pd;
      lock_req  = lr;
      lock_mask = lm;
      wp_en     = wp;
      rd_addr   = ra[9:0];
      @(posedge clk);
      exp_rd   = mem_m[ra];
      pre_lock = lock_m;
      acc = 1'b0;
      rej = 1'b0;
      if (lr) begin
         if (wp) rej = 1'b1;
         else begin
            acc = 1'b1;
            lock_m = lock_m | lm;
         end
      end
      if (pr) begin
         if (wp || pre_lock[pa / 32] || mem_m[pa] !== 16'hFFFF) rej = 1'b1;
         else begin
            acc = 1'b1;
            mem_m[pa] = pd;
         end
      end
      @(negedge clk);
      check(tag, "rd_data", 32'(rd_data), 32'(exp_rd));
      check(tag, "ack", 32'(ack), 32'(acc));
      check(tag, "err", 32'(err), 32'(rej));
   endtask

   task automatic prog(string tag, int a, logic [15:0] d);
      cyc(tag, 1'b1, a, d, 1'b0, 32'h0, 1'b0, a);
   endtask

   task automatic rd(string tag, int a);
      cyc(tag, 1'b0, 0, 16'h0, 1'b0, 32'h0, 1'b0, a);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 1024; i++) mem_m[i] = 16'hFFFF;
      lock_m    = 32'h0;
      rst_n     = 1'b0;
      prog_req  = 1'b0;
      prog_addr = '0;
      prog_data = '0;
      lock_req  = 1'b0;
      lock_mask = '0;
      wp_en     = 1'b0;
      rd_addr   = 10'd1023;
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1", "rd_data", 32'(rd_data), 32'hFFFF);
      check("R1", "ack", 32'(ack), 32'h0);
      check("R1", "err", 32'(err), 32'h0);
      rst_n = 1'b1;
      rd("R1", 0);
      rd("R1", 1023);
      // R1: no group locked after reset, so a word in the last group programs
      prog("R1", 1000, 16'h0F0F);

      // R3, R2: program a blank word and read it back
      prog("R3", 5, 16'h1234);
      rd("R2", 5);
      // R4: one-time rule
      prog("R4", 5, 16'h0000);
      rd("R4", 5);
      // R2: read and program of the same word in one cycle shows the old value
      cyc("R2", 1'b1, 7, 16'h5555, 1'b0, 32'h0, 1'b0, 7);
      rd("R2", 7);
      // R10: all-ones program keeps the word blank
      prog("R10", 6, 16'hFFFF);
      prog("R10", 6, 16'hABCD);
      rd("R10", 6);

      // R6, R5: lock group 2 (words 64..95)
      cyc("R6", 1'b0, 0, 16'h0, 1'b1, 32'h0000_0004, 1'b0, 0);
      prog("R5", 64, 16'h1111);
      prog("R5", 95, 16'h2222);
      prog("R5", 63, 16'h3333);
      prog("R5", 96, 16'h4444);
      rd("R5", 64);
      // R6: an all-zero mask leaves group 2 locked
      cyc("R6", 1'b0, 0, 16'h0, 1'b1, 32'h0, 1'b0, 0);
      prog("R6", 70, 16'h7777);

      // R7: write protect refuses programs and lock requests
      cyc("R7", 1'b1, 200, 16'h0101, 1'b0, 32'h0, 1'b1, 200);
      cyc("R7", 1'b0, 0, 16'h0, 1'b1, 32'h0000_0080, 1'b1, 0);
      rd("R7", 200);
      prog("R7", 224, 16'h0202);
      prog("R7", 200, 16'h0303);

      // R8: same-cycle lock and program judged on the earlier lock word
      cyc("R8", 1'b1, 320, 16'hAAAA, 1'b1, 32'h0000_0400, 1'b0, 320);
      prog("R8", 321, 16'hBBBB);
      cyc("R8", 1'b1, 80, 16'hCCCC, 1'b1, 32'h0000_0800, 1'b0, 80);
      prog("R8", 352, 16'hDDDD);

      // R9: idle cycles
      repeat (3) rd("R9", 320);

      // R8: mixed traffic
      for (int i = 0; i < 600; i++) begin
         bit pr;
         bit lr;
         bit wp;
         int pa;
         logic [31:0] lm;
         pr = ($urandom_range(0, 3) != 0);
         lr = ($urandom_range(0, 9) == 0);
         wp = ($urandom_range(0, 7) == 0);
         pa = $urandom_range(0, 511);
         lm = 32'h1 << $urandom_range(0, 31);
         cyc("R8", pr, pa, 16'($urandom), lr, lm, wp, $urandom_range(0, 1023));
      end

      // R2: final sweep over every word
      for (int a = 0; a < 1024; a++) rd("R2", a);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule